// File: doc/BRIEF.md
# Serial Command LED Toggler

This block listens to an asynchronous serial line and treats each received byte as a command. The bit timing comes from the system clock. A byte equal to one of the ASCII digits '1' to '5' flips the matching LED output, and every other byte is dropped without effect. The block never transmits, so its transmit line stays at the idle level.

Inside, the receive line goes through a two-flop synchroniser. A frame engine then confirms the start bit at its midpoint and samples each later bit at its centre. A byte whose stop bit reads low is discarded. A byte that passes is presented with a single-cycle valid strobe to a decoder, which holds one toggle register per LED.

Top module: `uart_led_toggle`

## Requirements
- R1: After rst_ni is released, all five LED outputs read 0.
- R2: tx_o is 1 in every cycle, including during reset.
- R3: A frame has a low start bit, then eight data bits with bit 0 first, then a high stop bit. Each bit lasts CLK_HZ/BAUD clock cycles, and the line idles high.
- R4: A received byte 8'h31 ('1') toggles led_o[0]. Likewise 8'h32 toggles led_o[1], 8'h33 toggles led_o[2], 8'h34 toggles led_o[3] and 8'h35 toggles led_o[4]. No byte changes more than one LED.
- R5: A received byte outside 8'h31 to 8'h35 leaves every LED unchanged.
- R6: A frame whose stop bit samples low produces no valid byte and changes no LED.
- R7: A low pulse on rx_i shorter than half a bit period is rejected at the start-bit check. The receiver returns to idle and decodes the next proper frame correctly.
- R8: The internal byte-valid strobe is high for exactly one cycle per accepted frame. An LED changes only in the cycle after that strobe.
- R9: Sending the sequence '1' to '5' twice returns all LEDs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| led_o | output | 5 | LED outputs; bit 0 is the first LED |
| tx_o | output | 1 | Transmit line, held high |

## Verification
The bench sends single-digit commands, which exposes a receiver that shifts bits in the wrong order: such a receiver would see 8'h31 as 8'h8C and light nothing. The bench also sends near-miss bytes, namely '0', '6', and '1' with bit 7 set. A decoder that compares too few bits, or that is off by one in its range, would then toggle an LED. A frame with a low stop bit checks that framing errors are discarded and do not leak into the LEDs. A short glitch followed by a real frame catches a receiver that skips the midpoint start check, because such a receiver would fall out of alignment and decode garbage.

// File: rtl/uart_led_pkg.sv
package uart_led_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam int unsigned NUM_LEDS = 5;
  localparam logic [7:0] CMD_BASE = 8'h31;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_led_pkg::*;
#(
  parameter int unsigned BIT_CYCLES = 1250,
  parameter int unsigned DATA_BITS  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_s_i,
  output logic                 valid_o,
  output logic [DATA_BITS-1:0] data_o
);
  localparam int unsigned CNT_W  = $clog2(BIT_CYCLES);
  localparam int unsigned HALF   = BIT_CYCLES / 2;
  localparam int unsigned BCNT_W = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0]  FULL_END = CNT_W'(BIT_CYCLES - 1);
  localparam logic [CNT_W-1:0]  HALF_END = CNT_W'(HALF - 1);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(DATA_BITS - 1);

  rx_state_e             state_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [BCNT_W-1:0]     bit_q;
  logic [DATA_BITS-1:0]  shift_q;
  logic                  rx_prev_q;
  logic                  fall;

  assign fall = rx_prev_q & ~rx_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      shift_q   <= '0;
      rx_prev_q <= 1'b1;
      valid_o   <= 1'b0;
      data_o    <= '0;
    end else begin
      rx_prev_q <= rx_s_i;
      valid_o   <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (fall) state_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == HALF_END) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            // start must still be low at its midpoint
            state_q <= rx_s_i ? RX_IDLE : RX_DATA;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_DATA: begin
          if (cnt_q == FULL_END) begin
            cnt_q   <= '0;
            shift_q <= {rx_s_i, shift_q[DATA_BITS-1:1]};
            bit_q   <= bit_q + 1'b1;
            if (bit_q == LAST_BIT) state_q <= RX_STOP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_STOP: begin
          if (cnt_q == FULL_END) begin
            cnt_q   <= '0;
            state_q <= RX_IDLE;
            if (rx_s_i) begin
              valid_o <= 1'b1;
              data_o  <= shift_q;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import uart_led_pkg::*;
#(
  parameter int unsigned LEDS = NUM_LEDS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [7:0]      data_i,
  output logic [LEDS-1:0] led_o
);
  for (genvar i = 0; i < LEDS; i++) begin : g_led
    logic hit;
    assign hit = valid_i && (data_i == 8'(CMD_BASE + 8'(i)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  led_o[i] <= 1'b0;
      else if (hit) led_o[i] <= ~led_o[i];
    end
  end
endmodule

// File: rtl/uart_led_toggle.sv
module uart_led_toggle
  import uart_led_pkg::*;
#(
  parameter int unsigned CLK_HZ = 12_000_000,
  parameter int unsigned BAUD   = 9600
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_i,
  output logic [NUM_LEDS-1:0] led_o,
  output logic                tx_o
);
  localparam int unsigned BIT_CYCLES = CLK_HZ / BAUD;

  logic       rx_s;
  logic       byte_valid;
  logic [7:0] byte_data;

  rx_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_core #(.BIT_CYCLES(BIT_CYCLES), .DATA_BITS(8)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_s_i (rx_s),
    .valid_o(byte_valid),
    .data_o (byte_data)
  );

  cmd_decoder #(.LEDS(NUM_LEDS)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(byte_valid),
    .data_i (byte_data),
    .led_o  (led_o)
  );

  assign tx_o = 1'b1;
endmodule

// File: rtl/uart_led_toggle_chk.sv
module uart_led_toggle_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] led_o,
  input logic       tx_o,
  input logic       byte_valid,
  input logic [7:0] byte_data
);
  always_comb assert_tx_high_R2: assert (tx_o === 1'b1);

  assert_one_led_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(led_o ^ $past(led_o)) <= 1);

  assert_ignore_other_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid && (byte_data < 8'h31 || byte_data > 8'h35)) |=> $stable(led_o));

  assert_strobe_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid |=> !byte_valid);

  assert_led_after_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(led_o) |-> $past(byte_valid));
endmodule

bind uart_led_toggle uart_led_toggle_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .led_o     (led_o),
  .tx_o      (tx_o),
  .byte_valid(byte_valid),
  .byte_data (byte_data)
);

// File: tb/uart_led_toggle_bench.sv
module uart_led_toggle_bench;
  localparam int unsigned CLK_HZ = 160_000;
  localparam int unsigned BAUD   = 10_000;
  localparam int unsigned BITC   = CLK_HZ / BAUD;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic [4:0] led_o;
  logic       tx_o;
  logic [4:0] exp_led = '0;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #10 clk_i = ~clk_i;

  uart_led_toggle #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_uart_led_toggle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .led_o (led_o),
    .tx_o  (tx_o)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: led/tx actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BITC) @(negedge clk_i);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop_ok);
    rx_i = 1'b0;
    wait_bits(1);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      wait_bits(1);
    end
    rx_i = stop_ok;
    wait_bits(1);
    rx_i = 1'b1;
    wait_bits(2);
    check("R2", {4'b0, tx_o}, 5'b00001);
  endtask

  function automatic logic [4:0] model(input logic [4:0] cur, input logic [7:0] b);
    if (b >= 8'h31 && b <= 8'h35) return cur ^ (5'b1 << (b - 8'h31));
    return cur;
  endfunction

  task automatic t_reset();
    check("R1", led_o, 5'b0);
    check("R2", {4'b0, tx_o}, 5'b00001);
  endtask

  task automatic t_each_digit();
    for (int i = 0; i < 5; i++) begin
      send_byte(8'h31 + 8'(i), 1'b1);
      exp_led = model(exp_led, 8'h31 + 8'(i));
      check("R4/R3", led_o, exp_led);
    end
  endtask

  task automatic t_repeat();
    for (int i = 0; i < 5; i++) begin
      send_byte(8'h31 + 8'(i), 1'b1);
      exp_led = model(exp_led, 8'h31 + 8'(i));
    end
    check("R9", led_o, 5'b0);
  endtask

  task automatic t_other();
    logic [7:0] bad [4] = '{8'h30, 8'h36, 8'hB1, 8'h00};
    send_byte(8'h33, 1'b1);
    exp_led = model(exp_led, 8'h33);
    check("R4", led_o, 5'b00100);
    foreach (bad[i]) begin
      send_byte(bad[i], 1'b1);
      check("R5", led_o, exp_led);
    end
  endtask

  task automatic t_bad_stop();
    send_byte(8'h31, 1'b0);
    check("R6", led_o, exp_led);
  endtask

  task automatic t_glitch();
    rx_i = 1'b0;
    repeat (BITC / 4) @(negedge clk_i);
    rx_i = 1'b1;
    wait_bits(2);
    check("R7", led_o, exp_led);
    send_byte(8'h35, 1'b1);
    exp_led = model(exp_led, 8'h35);
    check("R7", led_o, exp_led);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R2", {4'b0, tx_o}, 5'b00001);
    rst_ni = 1'b1;
    wait_bits(2);
    t_reset();
    t_each_digit();
    t_repeat();
    t_other();
    t_bad_stop();
    t_glitch();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule